// File: doc/BRIEF.md
# Mode-Controlled EDAC Datapath

This block surrounds a single-error-correcting, double-error-detecting code engine with the latches and output controls needed to use it on a memory bus. A 32-bit data word and its 7-bit check word enter through a data input register and a check input register. A 32-bit output data register holds a corrected (or diagnostic) word that can be driven back onto the data bus one byte at a time. Two select lines pick one of four operating modes. The same select lines decide which input registers load on each clock. This covers plain reads with error flags, correction with a syndrome report, read-modify-write byte merges with check-word regeneration, and self-test against a frozen check word.

The mode sequencer is a four-state machine whose state is the mode in force after each clock edge. The states are GEN (generate, select 00), DIAG (diagnostic, 01), FLAG (read and flag, 10) and CORR (latch and correct, 11). From every state there is a transition to every state, including itself, and the select lines name the target. Entering or staying in GEN or FLAG loads both input registers. Entering or staying in DIAG loads only the data register. Entering or staying in CORR loads neither. Bidirectional pins are split into separate input, output and output-enable signals. All registers are clocked, so every output reflects the inputs seen at the previous rising clock edge.

Top module: `edac_datapath`

## Requirements
- R1: While reset is low, the data input, check input and output registers clear to zero, the state is GEN and the capture-strobe history reads high. The outputs then show db_o = 0, cb_o = 0 and both flags low.
- R2: In state GEN, err_o and merr_o are 0 and cb_o carries the check word of the merged word (R10).
- R3: The code is fixed as follows. Data bit i has as its column the i-th 7-bit value, in ascending order, with exactly three ones; check bit j has the one-hot column with bit j set. Check bit j is the XOR of the data bits whose column has bit j set. The syndrome is the stored check register XOR the check word of the data register.
- R4: On a rising clock edge with sel_i = 10 both input registers load db_i and cb_i. In state FLAG the flags report the decode of the registered word.
- R5: If the syndrome is zero, both flags are 0. If the syndrome is one-hot, or equals the column of a data bit, err_o = 1 and merr_o = 0, and the corrected word is the data register with that data bit inverted, if any. For any other syndrome err_o = 1 and merr_o = 1, and the corrected word is the unmodified data register.
- R6: On an edge with sel_i = 11 neither input register loads. In state CORR cb_o carries the syndrome.
- R7: On an edge with sel_i = 01 the data register loads db_i and the check register holds. In state DIAG cb_o carries the held check register and the flags report the decode of the new data against it.
- R8: The output register loads only on an edge where led_i is 1 and was 0 at the previous edge. It takes the raw data register when the state before that edge is DIAG and the corrected word otherwise.
- R9: In every state db_o equals the output register and db_oe_o[n] = NOT oeb_i[n]. Bit n covers data bits 8n+7 down to 8n.
- R10: Byte n of the merged word is taken from the data input register when oeb_i[n] = 1 and from the output register when oeb_i[n] = 0.
- R11: cb_oe_o = NOT oecb_i in states GEN, DIAG and CORR, and cb_oe_o = 0 in state FLAG.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| sel_i | input | 2 | Mode select: 00 GEN, 01 DIAG, 10 FLAG, 11 CORR |
| db_i | input | 32 | Data bus value seen at the pins |
| cb_i | input | 7 | Check bus value seen at the pins |
| oeb_i | input | 4 | Per-byte data drive disable, 1 releases the byte |
| oecb_i | input | 1 | Check bus drive disable, 1 releases the bus |
| led_i | input | 1 | Output register capture strobe, rising level captures |
| db_o | output | 32 | Data bus drive value (output register) |
| db_oe_o | output | 4 | Per-byte data bus drive enable |
| cb_o | output | 7 | Check bus drive value: check word, syndrome or held check |
| cb_oe_o | output | 1 | Check bus drive enable |
| err_o | output | 1 | Error detected |
| merr_o | output | 1 | Uncorrectable error detected |

## Verification
The assertions assume that sel_i, led_i, oeb_i and oecb_i are clean levels sampled once per rising edge. They also assume that a capture strobe is a level that must be seen low at one edge before it counts as a new capture. The stimulus changes every input only on the falling clock edge and holds it for whole cycles, so each mode and strobe level is seen by exactly one or more complete edges. Diagnostic and correction sequences enter CORR and DIAG only after a FLAG cycle has loaded a known word and check. This keeps the hold checks on cb_o tied to defined register contents.

// File: rtl/edac_pkg.sv
package edac_pkg;

    localparam int DATA_W = 32;
    localparam int CHK_W  = 7;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_GEN  = 2'b00,
        ST_DIAG = 2'b01,
        ST_FLAG = 2'b10,
        ST_CORR = 2'b11
    } mode_e;

    // Column of data bit idx: idx-th value of weight three in ascending
    // order, followed by weight-five values if more columns were needed.
    function automatic logic [CHK_W-1:0] col_of(input int idx);
        int                 n;
        logic [CHK_W-1:0]   r;
        n = 0;
        r = '0;
        for (int w = 3; w <= 5; w += 2) begin
            for (int v = 0; v < (1 << CHK_W); v++) begin
                if ($countones(v) == w) begin
                    if (n == idx) r = v[CHK_W-1:0];
                    n++;
                end
            end
        end
        return r;
    endfunction

    // Data bits that feed check bit j.
    function automatic logic [DATA_W-1:0] row_mask(input int j);
        logic [DATA_W-1:0]  m;
        logic [CHK_W-1:0]   c;
        m = '0;
        for (int i = 0; i < DATA_W; i++) begin
            c    = col_of(i);
            m[i] = c[j];
        end
        return m;
    endfunction

endpackage

// File: rtl/edac_parity.sv
module edac_parity
    import edac_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CHK_W
) (
    input  logic [DW-1:0] data_i,
    output logic [CW-1:0] chk_o
);

    for (genvar j = 0; j < CW; j++) begin : g_row
        localparam logic [DW-1:0] MASK = DW'(row_mask(j));
        assign chk_o[j] = ^(data_i & MASK);
    end

endmodule

// File: rtl/edac_decode.sv
module edac_decode
    import edac_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CHK_W
) (
    input  logic [CW-1:0] syn_i,
    output logic [DW-1:0] flip_o,
    output logic          err_o,
    output logic          merr_o
);

    logic [DW-1:0] hit;

    for (genvar i = 0; i < DW; i++) begin : g_col
        localparam logic [CW-1:0] COL = col_of(i);
        assign hit[i] = (syn_i == COL);
    end

    assign flip_o = hit;
    assign err_o  = |syn_i;
    assign merr_o = (|syn_i) && !(|hit) && !$onehot(syn_i);

endmodule

// File: rtl/edac_mode_fsm.sv
module edac_mode_fsm
    import edac_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] sel_i,
    input  logic       led_i,
    output mode_e      state_o,
    output logic       dlat_en_o,
    output logic       clat_en_o,
    output logic       olat_en_o
);

    mode_e state_q;
    mode_e state_d;
    logic  led_q;

    assign state_d = mode_e'(sel_i);

    // State register: the mode in force after each edge.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_GEN;
            led_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            led_q   <= led_i;
        end
    end

    // Output process: register load enables for the coming edge.
    always_comb begin
        unique case (state_d)
            ST_GEN:  begin dlat_en_o = 1'b1; clat_en_o = 1'b1; end
            ST_DIAG: begin dlat_en_o = 1'b1; clat_en_o = 1'b0; end
            ST_FLAG: begin dlat_en_o = 1'b1; clat_en_o = 1'b1; end
            ST_CORR: begin dlat_en_o = 1'b0; clat_en_o = 1'b0; end
        endcase
        olat_en_o = led_i & ~led_q;
    end

    assign state_o = state_q;

endmodule

// File: rtl/edac_datapath.sv
module edac_datapath
    import edac_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CHK_W,
    parameter int BW = BYTE_W,
    localparam int NB = DW / BW
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [1:0]    sel_i,
    input  logic [DW-1:0] db_i,
    input  logic [CW-1:0] cb_i,
    input  logic [NB-1:0] oeb_i,
    input  logic          oecb_i,
    input  logic          led_i,
    output logic [DW-1:0] db_o,
    output logic [NB-1:0] db_oe_o,
    output logic [CW-1:0] cb_o,
    output logic          cb_oe_o,
    output logic          err_o,
    output logic          merr_o
);

    mode_e         state_q;
    logic          dlat_en, clat_en, olat_en;
    logic [DW-1:0] dlat_q, olat_q, merged, fixed, flip;
    logic [CW-1:0] clat_q, rd_chk, wr_chk, syn;
    logic          dec_err, dec_merr;

    edac_mode_fsm u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .sel_i     (sel_i),
        .led_i     (led_i),
        .state_o   (state_q),
        .dlat_en_o (dlat_en),
        .clat_en_o (clat_en),
        .olat_en_o (olat_en)
    );

    // Input and output registers.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            dlat_q <= '0;
            clat_q <= '0;
            olat_q <= '0;
        end else begin
            if (dlat_en) dlat_q <= db_i;
            if (clat_en) clat_q <= cb_i;
            if (olat_en) olat_q <= (state_q == ST_DIAG) ? dlat_q : fixed;
        end
    end

    // Per-byte merge and drive enables.
    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign merged[b*BW +: BW] = oeb_i[b] ? dlat_q[b*BW +: BW] : olat_q[b*BW +: BW];
        assign db_oe_o[b]         = ~oeb_i[b];
    end

    assign db_o = olat_q;

    edac_parity #(.DW(DW), .CW(CW)) u_rd_par (
        .data_i (dlat_q),
        .chk_o  (rd_chk)
    );

    edac_parity #(.DW(DW), .CW(CW)) u_wr_par (
        .data_i (merged),
        .chk_o  (wr_chk)
    );

    assign syn = rd_chk ^ clat_q;

    edac_decode #(.DW(DW), .CW(CW)) u_dec (
        .syn_i  (syn),
        .flip_o (flip),
        .err_o  (dec_err),
        .merr_o (dec_merr)
    );

    assign fixed = dlat_q ^ flip;

    // Output process keyed on the current state.
    always_comb begin
        unique case (state_q)
            ST_GEN: begin
                cb_o    = wr_chk;
                cb_oe_o = ~oecb_i;
                err_o   = 1'b0;
                merr_o  = 1'b0;
            end
            ST_DIAG: begin
                cb_o    = clat_q;
                cb_oe_o = ~oecb_i;
                err_o   = dec_err;
                merr_o  = dec_merr;
            end
            ST_FLAG: begin
                cb_o    = syn;
                cb_oe_o = 1'b0;
                err_o   = dec_err;
                merr_o  = dec_merr;
            end
            ST_CORR: begin
                cb_o    = syn;
                cb_oe_o = ~oecb_i;
                err_o   = dec_err;
                merr_o  = dec_merr;
            end
        endcase
    end

endmodule

// File: rtl/edac_datapath_chk.sv
module edac_datapath_chk #(
    parameter int DW = 32,
    parameter int CW = 7
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic [1:0]    sel_i,
    input logic          led_i,
    input logic [DW-1:0] db_o,
    input logic [CW-1:0] cb_o,
    input logic          cb_oe_o,
    input logic          err_o,
    input logic          merr_o,
    input logic [1:0]    state_q
);

    p_gen_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == 2'b00) |-> (!err_o && !merr_o));

    p_merr_implies_err_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        merr_o |-> err_o);

    p_flag_no_drive_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == 2'b10) |-> !cb_oe_o);

    p_olat_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !led_i |=> $stable(db_o));

    p_corr_syn_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == 2'b11 && sel_i == 2'b11) |=> $stable(cb_o));

    p_diag_chk_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == 2'b01 && sel_i == 2'b01) |=> $stable(cb_o));

endmodule

bind edac_datapath edac_datapath_chk #(.DW(DW), .CW(CW)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (sel_i),
    .led_i   (led_i),
    .db_o    (db_o),
    .cb_o    (cb_o),
    .cb_oe_o (cb_oe_o),
    .err_o   (err_o),
    .merr_o  (merr_o),
    .state_q (state_q)
);

// File: tb/edac_datapath_bench.sv
module edac_datapath_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  sel = 2'b00;
    logic [31:0] db_in = '0;
    logic [6:0]  cb_in = '0;
    logic [3:0]  oeb = 4'hF;
    logic        oecb = 1'b0;
    logic        led = 1'b0;
    logic [31:0] db_out;
    logic [3:0]  db_oe;
    logic [6:0]  cb_out;
    logic        cb_oe, err, merr;

    always #10 clk = ~clk;

    edac_datapath u_edac_datapath (
        .clk_i (clk), .rst_ni (rst_n), .sel_i (sel), .db_i (db_in), .cb_i (cb_in),
        .oeb_i (oeb), .oecb_i (oecb), .led_i (led), .db_o (db_out), .db_oe_o (db_oe),
        .cb_o (cb_out), .cb_oe_o (cb_oe), .err_o (err), .merr_o (merr)
    );

    typedef struct {
        string       tag;
        logic [31:0] db;
        logic [3:0]  dboe;
        logic [6:0]  cb;
        logic        cboe;
        logic        err;
        logic        merr;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    // Reference state built from the requirements.
    logic [31:0] m_d = '0, m_c32, m_o = '0;
    logic [6:0]  m_c = '0;
    logic        m_ledq = 1'b1;
    logic [1:0]  m_st = 2'b00;

    // R3: column i is the i-th weight-three 7-bit value in ascending order.
    function automatic logic [6:0] b_col(input int idx);
        int         k = 0;
        logic [6:0] r = '0;
        for (int v = 0; v < 128; v++) begin
            if ($countones(v) == 3) begin
                if (k == idx) r = v[6:0];
                k++;
            end
        end
        return r;
    endfunction

    function automatic logic [6:0] b_gen(input logic [31:0] w);
        logic [6:0] c = '0;
        for (int i = 0; i < 32; i++) if (w[i]) c = c ^ b_col(i);
        return c;
    endfunction

    function automatic int b_match(input logic [6:0] s);
        int hit = -1;
        for (int i = 0; i < 32; i++) if (b_col(i) == s) hit = i;
        return hit;
    endfunction

    task automatic step(input logic [1:0] s, input logic [31:0] d, input logic [6:0] c,
                        input logic [3:0] ob, input logic ocb, input logic l, input string tag);
        exp_t        e;
        logic [6:0]  syn;
        logic [31:0] fx, mg;
        int          pos;
        @(negedge clk);
        sel = s; db_in = d; cb_in = c; oeb = ob; oecb = ocb; led = l;
        // model of the coming edge, pre-edge state first (R8)
        if (l && !m_ledq) begin
            syn = b_gen(m_d) ^ m_c;
            pos = b_match(syn);
            fx  = m_d;
            if (pos >= 0) fx[pos] = ~fx[pos];
            m_o = (m_st == 2'b01) ? m_d : fx;
        end
        if (s != 2'b11) m_d = d;
        if (s == 2'b00 || s == 2'b10) m_c = c;
        m_ledq = l;
        m_st   = s;
        // expected outputs after the edge
        syn = b_gen(m_d) ^ m_c;
        pos = b_match(syn);
        for (int b = 0; b < 4; b++) mg[b*8 +: 8] = ob[b] ? m_d[b*8 +: 8] : m_o[b*8 +: 8];
        e.tag  = tag;
        e.db   = m_o;
        e.dboe = ~ob;
        e.err  = (syn != 0);
        e.merr = (syn != 0) && (pos < 0) && ($countones(syn) != 1);
        case (s)
            2'b00:   begin e.cb = b_gen(mg); e.cboe = ~ocb; e.err = 0; e.merr = 0; end
            2'b01:   begin e.cb = m_c;       e.cboe = ~ocb; end
            2'b10:   begin e.cb = syn;       e.cboe = 1'b0; end
            default: begin e.cb = syn;       e.cboe = ~ocb; end
        endcase
        exp_q.push_back(e);
    endtask

    // Monitor: pop one expectation per edge and compare.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                checks++;
                if (db_out !== e.db || db_oe !== e.dboe || cb_oe !== e.cboe ||
                    err !== e.err || merr !== e.merr || (e.cboe && cb_out !== e.cb)) begin
                    errors++;
                    $display("FAIL %s: actual db=%h oe=%b cb=%h cboe=%b err=%b merr=%b expected db=%h oe=%b cb=%h cboe=%b err=%b merr=%b",
                             e.tag, db_out, db_oe, cb_out, cb_oe, err, merr,
                             e.db, e.dboe, e.cb, e.cboe, e.err, e.merr);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] a;
        logic [6:0]  ca;
        a  = 32'hCAFE_1234;
        ca = b_gen(a);
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (db_out !== 32'h0 || err !== 1'b0 || merr !== 1'b0 || cb_out !== 7'h0 || cb_oe !== 1'b1) begin
            errors++;
            $display("FAIL R1 reset: actual db=%h cb=%h err=%b merr=%b cboe=%b expected db=0 cb=0 err=0 merr=0 cboe=1",
                     db_out, cb_out, err, merr, cb_oe);
        end
        @(negedge clk);
        rst_n = 1'b1;

        step(2'b00, a, 7'h00, 4'hF, 1'b0, 1'b0, "R2 R3 R10 generate from external word");
        step(2'b00, 32'h0000_0001, 7'h55, 4'hF, 1'b0, 1'b0, "R3 single data bit column");
        step(2'b10, a, ca, 4'hF, 1'b0, 1'b0, "R4 R5 clean read");
        step(2'b10, a ^ 32'h0000_0020, ca, 4'hF, 1'b0, 1'b0, "R5 single data error");
        step(2'b10, a, ca ^ 7'h08, 4'hF, 1'b0, 1'b0, "R5 single check error");
        step(2'b10, a ^ 32'h0000_0300, ca, 4'hF, 1'b0, 1'b0, "R5 double data error");
        step(2'b10, a ^ 32'h0002_0000, ca, 4'hF, 1'b0, 1'b0, "R4 load word for correction");
        step(2'b11, 32'hFFFF_FFFF, 7'h00, 4'hF, 1'b0, 1'b0, "R6 registers hold in correct");
        step(2'b11, 32'hFFFF_FFFF, 7'h00, 4'hF, 1'b0, 1'b1, "R8 capture corrected word");
        step(2'b11, 32'hFFFF_FFFF, 7'h00, 4'b0010, 1'b0, 1'b0, "R9 byte drive enables");
        step(2'b00, 32'h0000_5A00, 7'h00, 4'b0010, 1'b0, 1'b0, "R10 merge external byte one");
        step(2'b00, 32'h0000_5A00, 7'h00, 4'b1001, 1'b1, 1'b0, "R11 R10 check port released");
        step(2'b10, a, ca, 4'h0, 1'b0, 1'b0, "R11 R7 flag mode loads known check");
        step(2'b01, a ^ 32'h0000_0200, 7'h7F, 4'hF, 1'b0, 1'b0, "R7 diagnostic single error");
        step(2'b01, a ^ 32'h0010_0200, 7'h7F, 4'hF, 1'b0, 1'b0, "R7 diagnostic double error");
        step(2'b01, a ^ 32'h0000_0200, 7'h00, 4'hF, 1'b0, 1'b1, "R8 diagnostic capture raw word");
        step(2'b11, 32'h0, 7'h00, 4'hF, 1'b0, 1'b0, "R6 syndrome of diagnostic word");
        step(2'b11, 32'h0, 7'h00, 4'hF, 1'b0, 1'b1, "R8 capture corrected diagnostic word");
        step(2'b10, ~a, b_gen(~a), 4'hF, 1'b0, 1'b1, "R8 held strobe does not recapture");
        step(2'b10, ~a, b_gen(~a) ^ 7'h03, 4'hF, 1'b0, 1'b0, "R5 double check error");

        repeat (2) @(posedge clk);
        #5;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule